// File: doc/BRIEF.md
# Serial Byte Link with Acknowledge

This block is one end of a two-wire, point-to-point serial byte link. Each direction of the link has a single line, and each line carries two kinds of packet: data packets that move one byte, and two-bit acknowledge packets that give flow control for the other direction. A packet starts with a 1 bit, and its second bit tells the two kinds apart. The line rests low between packets.

On the transmit side, bytes are taken from a valid/ready interface and sent one at a time. After a byte has been accepted, the block takes no further byte until the far end has acknowledged it. When `tx_ready_o` is high, every byte sent so far has been acknowledged, so a multi-byte message is complete at that point. On the receive side, the block watches the incoming line and writes decoded bytes into a one-byte output buffer. It sends an acknowledge as soon as a data packet is recognised, not when the packet ends, so a willing consumer receives back-to-back bytes with no gaps. If the buffer is still full when a new byte begins, the acknowledge is held back until room appears.

The two ends need no shared clock and no phase reference. The input line is synchronised, and each bit is sampled near its middle, using a bit period set in local clock cycles. Both ends must use the same period.

Top module: `serial_byte_link`

## Requirements
- R1: After reset `line_o` is low, `tx_ready_o` is high and `rx_valid_o` is low. `line_o` stays low while there is nothing to send.
- R2: A data packet on `line_o` is 11 bits long. Each bit lasts BIT_CYCLES clocks. The order is a 1 start bit, a 1 kind bit, the eight data bits least significant first, then a 0 stop bit.
- R3: An acknowledge packet on `line_o` is a 1 start bit followed by a 0 kind bit. Each bit lasts BIT_CYCLES clocks.
- R4: `tx_ready_o` falls when a byte is accepted (`tx_valid_i` and `tx_ready_o` both high). It stays low until an acknowledge packet arrives on `line_i` after that byte has begun transmission. An acknowledge that arrives while no byte is outstanding has no effect.
- R5: A data packet on `line_i` produces its byte on `rx_data_o` with `rx_valid_o` high. Both hold until `rx_ready_i` is high.
- R6: When the output buffer is empty or is being read, the acknowledge for an incoming data packet starts on `line_o` before that packet has finished on `line_i`.
- R7: When the output buffer is full as an incoming data packet begins, no acknowledge is sent until the buffer is read. The new byte is then presented next.
- R8: When the line becomes free and both an acknowledge and a data byte are waiting to be sent, the acknowledge packet goes first.
- R9: With `line_o` looped back to `line_i`, a sequence of bytes comes out on `rx_data_o` in the order it went in. `tx_ready_o` returns high only after the last byte has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte to send is present |
| tx_ready_o | output | 1 | Byte can be accepted; all earlier bytes are acknowledged |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte is present |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| line_o | output | 1 | Outgoing serial line |
| line_i | input | 1 | Incoming serial line, asynchronous |

## Verification
The hardest case to produce is R8, because an acknowledge and a data byte must both be waiting at the moment the line frees up. The bench gets there while the block is still sending a byte. Part way through that packet, the bench acknowledges the byte early and offers a second byte at once. It then starts a data packet on the incoming line, which queues an acknowledge. When the first packet ends, both packets are waiting, and the decoded outgoing order must be acknowledge, then data. The deferred acknowledge of R7 is reached by holding `rx_ready_i` low across two incoming bytes.

// File: rtl/slink_pkg.sv
package slink_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DATA_PKT_BITS = BYTE_W + 3;
  localparam int unsigned ACK_PKT_BITS = 2;
  localparam int unsigned BITS_W = $clog2(DATA_PKT_BITS + 1);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_KIND,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/slink_sync.sv
module slink_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/slink_rx_deframe.sv
module slink_rx_deframe
  import slink_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              ack_seen_o,
  output logic              data_begin_o,
  output logic              data_done_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CW = $clog2(BIT_CYCLES + 1);
  localparam int unsigned HALF = BIT_CYCLES / 2;

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        idx_q;
  logic [BYTE_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_IDLE;
      cnt_q        <= '0;
      idx_q        <= '0;
      shreg_q      <= '0;
      ack_seen_o   <= 1'b0;
      data_begin_o <= 1'b0;
      data_done_o  <= 1'b0;
    end else begin
      ack_seen_o   <= 1'b0;
      data_begin_o <= 1'b0;
      data_done_o  <= 1'b0;
      if (state_q == RX_IDLE) begin
        if (line_i) begin
          cnt_q   <= CW'(HALF - 1);
          state_q <= RX_START;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= CW'(BIT_CYCLES - 1);
        unique case (state_q)
          RX_START: state_q <= line_i ? RX_KIND : RX_IDLE;
          RX_KIND: begin
            // kind bit: 1 = data follows, 0 = acknowledge complete
            if (line_i) begin
              data_begin_o <= 1'b1;
              idx_q        <= '0;
              state_q      <= RX_DATA;
            end else begin
              ack_seen_o <= 1'b1;
              state_q    <= RX_IDLE;
            end
          end
          RX_DATA: begin
            shreg_q <= {line_i, shreg_q[BYTE_W-1:1]};
            idx_q   <= idx_q + 1'b1;
            if (idx_q == 3'd7) state_q <= RX_STOP;
          end
          RX_STOP: begin
            data_done_o <= 1'b1;
            state_q     <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = shreg_q;
endmodule

// File: rtl/slink_tx_frame.sv
module slink_tx_frame
  import slink_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_req_i,
  input  logic              data_valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              data_take_o,
  output logic              ack_start_o,
  output logic              ack_pend_o,
  output logic              line_o
);
  localparam int unsigned CW = $clog2(BIT_CYCLES + 1);

  logic [CW-1:0]            cnt_q;
  logic [BITS_W-1:0]        left_q;
  logic [DATA_PKT_BITS-2:0] shreg_q;
  logic                     line_q;
  logic                     ack_pend_q;
  logic                     slot_free;

  assign slot_free   = (cnt_q == '0) && (left_q == '0);
  assign ack_start_o = slot_free && ack_pend_q;
  assign data_take_o = slot_free && !ack_pend_q && data_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      left_q     <= '0;
      shreg_q    <= '0;
      line_q     <= 1'b0;
      ack_pend_q <= 1'b0;
    end else begin
      ack_pend_q <= (ack_pend_q && !ack_start_o) || ack_req_i;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (left_q != '0) begin
        line_q  <= shreg_q[0];
        shreg_q <= shreg_q >> 1;
        left_q  <= left_q - 1'b1;
        cnt_q   <= CW'(BIT_CYCLES - 1);
      end else if (ack_start_o) begin
        line_q  <= 1'b1;
        shreg_q <= '0;  // kind bit 0
        left_q  <= BITS_W'(ACK_PKT_BITS - 1);
        cnt_q   <= CW'(BIT_CYCLES - 1);
      end else if (data_take_o) begin
        line_q  <= 1'b1;
        shreg_q <= {1'b0, data_i, 1'b1};  // stop, byte lsb first, kind 1
        left_q  <= BITS_W'(DATA_PKT_BITS - 1);
        cnt_q   <= CW'(BIT_CYCLES - 1);
      end else begin
        line_q <= 1'b0;
      end
    end
  end

  assign line_o     = line_q;
  assign ack_pend_o = ack_pend_q;
endmodule

// File: rtl/serial_byte_link.sv
module serial_byte_link
  import slink_pkg::*;
#(
  parameter int unsigned BIT_CYCLES  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              line_o,
  input  logic              line_i
);
  logic              line_s;
  logic              ack_seen, data_begin, data_done;
  logic [BYTE_W-1:0] deframe_byte;
  logic              data_take, ack_start, ack_pend, ack_req;

  logic              tx_full_q, tx_out_q;
  logic [BYTE_W-1:0] tx_buf_q;
  logic              rx_valid_q, held_q, ack_owed_q;
  logic [BYTE_W-1:0] rx_buf_q;
  logic              accept, pop, room;

  slink_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  slink_rx_deframe #(.BIT_CYCLES(BIT_CYCLES)) i_deframe (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_s),
    .ack_seen_o(ack_seen), .data_begin_o(data_begin),
    .data_done_o(data_done), .data_o(deframe_byte)
  );

  slink_tx_frame #(.BIT_CYCLES(BIT_CYCLES)) i_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_req_i(ack_req),
    .data_valid_i(tx_full_q), .data_i(tx_buf_q),
    .data_take_o(data_take), .ack_start_o(ack_start),
    .ack_pend_o(ack_pend), .line_o(line_o)
  );

  // transmit: one byte outstanding until acknowledged
  assign accept = tx_valid_i && !tx_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_q <= 1'b0;
      tx_out_q  <= 1'b0;
      tx_buf_q  <= '0;
    end else begin
      if (accept) begin
        tx_buf_q  <= tx_data_i;
        tx_full_q <= 1'b1;
        tx_out_q  <= 1'b1;
      end else begin
        if (data_take) tx_full_q <= 1'b0;
        // ack only counts once the byte has left the holding register
        if (ack_seen && !tx_full_q) tx_out_q <= 1'b0;
      end
    end
  end

  // receive: output buffer plus parked byte in the deframer
  assign pop     = rx_valid_q && rx_ready_i;
  assign room    = !rx_valid_q || pop;
  assign ack_req = ack_owed_q && room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_buf_q   <= '0;
      held_q     <= 1'b0;
      ack_owed_q <= 1'b0;
    end else begin
      if (data_begin)   ack_owed_q <= 1'b1;
      else if (ack_req) ack_owed_q <= 1'b0;

      if (data_done) begin
        if (room) begin
          rx_buf_q   <= deframe_byte;
          rx_valid_q <= 1'b1;
        end else begin
          held_q <= 1'b1;
        end
      end else if (held_q && room) begin
        rx_buf_q   <= deframe_byte;
        rx_valid_q <= 1'b1;
        held_q     <= 1'b0;
      end else if (pop) begin
        rx_valid_q <= 1'b0;
      end
    end
  end

  assign tx_ready_o = !tx_out_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_buf_q;
endmodule

// File: rtl/slink_checker.sv
module slink_checker
  import slink_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [BYTE_W-1:0] rx_data_o,
  input logic              ack_seen,
  input logic              held_q,
  input logic              data_take,
  input logic              ack_start,
  input logic              ack_pend
);
  assert_ready_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_valid_i));

  assert_ready_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> $past(ack_seen));

  assert_rx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  assert_park_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> rx_valid_o);

  assert_ack_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_take |-> !ack_pend);

  assert_one_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_take, ack_start}));
endmodule

bind serial_byte_link slink_checker i_slink_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .rx_data_o(rx_data_o), .ack_seen(ack_seen), .held_q(held_q),
  .data_take(data_take), .ack_start(ack_start), .ack_pend(ack_pend)
);

// File: tb/test_serial_byte_link.sv
module test_serial_byte_link;
  localparam int BIT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic       line_out;
  logic       drv_line = 1'b0;
  logic       loop_en = 1'b0;
  logic       line_in;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line_in = loop_en ? line_out : drv_line;

  serial_byte_link #(.BIT_CYCLES(BIT)) i_serial_byte_link (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .line_o(line_out), .line_i(line_in)
  );

  // decoder of line_out: kind 0 = ack, 1 = data
  int   mon_n = 0;
  int   mon_kind [64];
  logic [7:0] mon_byte [64];
  int   mon_cyc [64];
  int   mon_badframe = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (line_out) begin
        logic [7:0] b;
        logic       k;
        int         at;
        repeat (BIT / 2) @(negedge clk);
        if (!line_out) mon_badframe++;
        repeat (BIT) @(negedge clk);
        k  = line_out;
        at = cyc;
        if (k) begin
          for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = line_out;
          end
          repeat (BIT) @(negedge clk);
          if (line_out) mon_badframe++;
        end else b = '0;
        if (mon_n < 64) begin
          mon_kind[mon_n] = k ? 1 : 0;
          mon_byte[mon_n] = b;
          mon_cyc[mon_n]  = at;
          mon_n++;
        end
      end
    end
  end

  // log of bytes taken from the receive port
  int   rxl_n = 0;
  logic [7:0] rxl [64];
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready && rxl_n < 64) begin
      rxl[rxl_n] = rx_data;
      rxl_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bits_out(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drv_line = bits[i];
      repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk);
    drv_line = 1'b0;
  endtask

  task automatic peer_data(input logic [7:0] d);
    bits_out({1'b0, d, 1'b1, 1'b1}, 11);
  endtask

  task automatic peer_ack();
    bits_out(11'b01, 2);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_mon(input int n);
    int t = 0;
    while (mon_n < n && t < 40 * BIT) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(line_out == 1'b0, "R1 line idle", line_out, 0);
    check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    repeat (3 * BIT) @(negedge clk);
    check(line_out == 1'b0 && mon_n == 0, "R1 quiet line", mon_n, 0);
  endtask

  task automatic t_tx_frame();
    int n0 = mon_n;
    push(8'hA5);
    check(tx_ready == 1'b0, "R4 ready low after accept", tx_ready, 0);
    wait_mon(n0 + 1);
    repeat (2 * BIT) @(negedge clk);
    check(mon_n == n0 + 1 && mon_kind[n0] == 1 && mon_byte[n0] == 8'hA5,
          "R2 data packet", mon_byte[n0], 8'hA5);
    check(mon_badframe == 0, "R2 start/stop bits", mon_badframe, 0);
    check(tx_ready == 1'b0, "R4 held until ack", tx_ready, 0);
    peer_ack();
    repeat (BIT) @(negedge clk);
    check(tx_ready == 1'b1, "R4 released by ack", tx_ready, 1);
  endtask

  task automatic t_stray_ack();
    int n0 = mon_n;
    peer_ack();
    repeat (2 * BIT) @(negedge clk);
    check(tx_ready == 1'b1, "R4 stray ack ignored", tx_ready, 1);
    check(mon_n == n0 && line_out == 1'b0, "R4 stray ack no output", mon_n, n0);
  endtask

  task automatic t_rx_early_ack();
    int n0 = mon_n;
    int fin;
    rx_ready = 1'b0;
    peer_data(8'h3C);
    fin = cyc;
    wait_mon(n0 + 1);
    check(mon_n == n0 + 1 && mon_kind[n0] == 0, "R3 ack packet", mon_kind[n0], 0);
    check(mon_cyc[n0] < fin, "R6 ack before packet end", mon_cyc[n0], fin);
    repeat (BIT) @(negedge clk);
    check(rx_valid == 1'b1 && rx_data == 8'h3C, "R5 byte presented", rx_data, 8'h3C);
  endtask

  task automatic t_rx_defer();
    int n0 = mon_n;
    peer_data(8'h77);
    repeat (3 * BIT) @(negedge clk);
    check(mon_n == n0, "R7 ack withheld", mon_n, n0);
    check(rx_valid == 1'b1 && rx_data == 8'h3C, "R5 byte held", rx_data, 8'h3C);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
    check(rx_valid == 1'b1 && rx_data == 8'h77, "R7 next byte presented", rx_data, 8'h77);
    wait_mon(n0 + 1);
    check(mon_n == n0 + 1 && mon_kind[n0] == 0, "R7 ack after read", mon_n, n0 + 1);
    rx_ready = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic t_ack_priority();
    int n0 = mon_n;
    int r0 = rxl_n;
    push(8'h11);
    while (!line_out) @(negedge clk);
    repeat (2 * BIT) @(negedge clk);
    peer_ack();
    fork
      peer_data(8'h5A);
      push(8'h22);
    join
    wait_mon(n0 + 3);
    check(mon_n == n0 + 3 && mon_kind[n0] == 1 && mon_byte[n0] == 8'h11,
          "R8 first packet", mon_byte[n0], 8'h11);
    check(mon_kind[n0 + 1] == 0, "R8 ack ahead of data", mon_kind[n0 + 1], 0);
    check(mon_kind[n0 + 2] == 1 && mon_byte[n0 + 2] == 8'h22,
          "R8 data after ack", mon_byte[n0 + 2], 8'h22);
    peer_ack();
    repeat (2 * BIT) @(negedge clk);
    check(rxl_n == r0 + 1 && rxl[r0] == 8'h5A, "R5 byte taken", rxl[r0], 8'h5A);
    check(tx_ready == 1'b1, "R4 released after second ack", tx_ready, 1);
  endtask

  task automatic t_loopback();
    int r0 = rxl_n;
    int t = 0;
    logic [7:0] seq [3] = '{8'h81, 8'h42, 8'hFF};
    loop_en = 1'b1;
    for (int i = 0; i < 3; i++) push(seq[i]);
    check(tx_ready == 1'b0, "R9 message not complete", tx_ready, 0);
    while (!tx_ready && t < 60 * BIT) begin
      @(negedge clk);
      t++;
    end
    check(tx_ready == 1'b1, "R9 message complete", tx_ready, 1);
    repeat (BIT) @(negedge clk);
    check(rxl_n == r0 + 3, "R9 byte count", rxl_n - r0, 3);
    for (int i = 0; i < 3; i++)
      check(rxl[r0 + i] == seq[i], "R9 order", rxl[r0 + i], seq[i]);
    check(mon_badframe == 0, "R2 frames in loopback", mon_badframe, 0);
    loop_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_frame();
    t_stray_ack();
    t_rx_early_ack();
    t_rx_defer();
    t_ack_priority();
    t_loopback();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule